// File: doc/BRIEF.md
# Two-Bank Edge Interrupt Controller

This block gathers 55 event lines from peripherals and general-purpose pins into a single combined interrupt line and a separate wake-request line. Every line is passed through a two-flop synchronizer. It is then compared against its previous level to find an edge. A per-source polarity bit chooses which direction counts. A detected edge latches a pending bit. The pending bit stays set until software writes a one to it. The combined interrupt is the OR of every pending bit whose enable bit is set.

Sources are split into two banks of 32 bits: source n sits in bank n/32 at bit n mod 32. Positions 27 to 31 have no source, and neither do the unused top positions of the second bank. Wake detection runs beside interrupt detection, with its own enable and polarity registers. An enabled wake edge gives a one-cycle pulse on the wake output. After software clears status, the combined output is held low for one cycle even when other enabled sources are still pending. It then comes back high, so a downstream edge detector sees a fresh edge.

Top module: `edge_intc`

## Requirements
- R1: After a synchronous active-low reset, the enable, polarity, pending, wake-enable and wake-polarity registers of both banks read zero, and `irq_out` and `wake_req` are low.
- R2: `bus_addr[0]` selects the bank, and `bus_addr[3:1]` selects the register: 0 pending status, 1 enable, 2 polarity, 3 wake enable, 4 wake polarity. Enable, polarity and both wake registers read back the value written to them, and a write changes only the addressed bank. Codes 5 to 7 read zero and ignore writes.
- R3: Source n maps to bit n mod 32 of bank n/32. With polarity 0, a rising input sets that pending bit and a falling input does not.
- R4: With polarity 1, a falling input sets the pending bit and a rising input does not.
- R5: Positions 27 to 31 of bank 0 and positions 23 to 31 of bank 1 always read zero in status and never raise `irq_out`, even when their enable bits are set.
- R6: Writing to a status register clears each pending bit written with a one and leaves each bit written with a zero unchanged.
- R7: `irq_out` is high when at least one bit is both pending and enabled. A pending bit whose enable is zero does not raise it, and setting that enable raises `irq_out` one cycle after the write.
- R8: A status write that has a one in any implemented bit forces `irq_out` low for the next cycle. If another enabled source is still pending, `irq_out` is high again in the cycle after that.
- R9: Changing a polarity bit while its input is steady counts as an edge when the input already sits at the level the new direction ends on. Two cases qualify: input low when switching to falling, and input high when switching to rising. The pending bit is then set one cycle after the write.
- R10: When an edge is detected in the same cycle as a status write that clears that bit, the bit stays pending.
- R11: When a source's wake-enable bit is set, an edge in the direction its wake-polarity bit selects (0 rising, 1 falling) gives a one-cycle high pulse on `wake_req`. This does not depend on the interrupt enable. When the wake-enable bit is zero, that source gives no pulse.
- R12: An input change sets the pending bit on the third rising clock edge after it, and `irq_out` follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 55 | Asynchronous event inputs, one per source |
| bus_addr | input | 4 | Word address: bit 0 bank, bits 3:1 register code |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_out | output | 1 | Combined interrupt |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The hardest case to create from the ports is the collision in which a clear write reaches the pending register on the same clock edge as a new edge on that bit. The edge only exists for the single cycle after the second synchronizer stage. The stimulus therefore drives the input, counts exactly two clock edges, and then issues the clear so that it lands on the third edge. A second clear afterwards shows that the bit really can be cleared. The one-cycle dip of the combined output is checked in the same way, by sampling in the two cycles right after a partial clear while a second enabled source is still pending.

// File: rtl/edge_intc_pkg.sv
// Shared register codes and types for the edge interrupt controller.
package edge_intc_pkg;
    typedef logic [2:0] reg_kind_t;

    localparam reg_kind_t KIND_STAT = 3'd0;  // pending status, write one to clear
    localparam reg_kind_t KIND_EN   = 3'd1;  // interrupt enable
    localparam reg_kind_t KIND_POL  = 3'd2;  // interrupt edge polarity
    localparam reg_kind_t KIND_WEN  = 3'd3;  // wake enable
    localparam reg_kind_t KIND_WPOL = 3'd4;  // wake edge polarity
endpackage

// File: rtl/edge_intc_sync.sv
// Two-flop synchronizer and polarity-aware edge detector for one bank.
// Assumes raw inputs are asynchronous levels. An edge is a 0->1 change of
// (synchronized level XOR polarity), so a polarity flip can also make one.
module edge_intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] wpol,
    output logic [W-1:0] irq_edge,
    output logic [W-1:0] wake_edge
);
    logic [W-1:0] s1_q, s2_q, prev_irq_q, prev_wake_q;
    logic [W-1:0] eff_irq, eff_wake;

    assign eff_irq  = s2_q ^ pol;
    assign eff_wake = s2_q ^ wpol;

    // Synchronize inputs and remember last effective levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q        <= '0;
            s2_q        <= '0;
            prev_irq_q  <= '0;
            prev_wake_q <= '0;
        end else begin
            s1_q        <= raw;
            s2_q        <= s1_q;
            prev_irq_q  <= eff_irq;
            prev_wake_q <= eff_wake;
        end
    end

    assign irq_edge  = eff_irq & ~prev_irq_q;
    assign wake_edge = eff_wake & ~prev_wake_q;
endmodule

// File: rtl/edge_intc_bank.sv
// Register set for one 32-bit bank: enable, polarity, wake enable, wake
// polarity and the write-one-to-clear pending bits. Positions without a
// source (beyond NUM_SRC or inside the hole range) never become pending.
// Assumes wr_en is already qualified by the bank select.
module edge_intc_bank
    import edge_intc_pkg::*;
#(
    parameter int W        = 32,
    parameter int BANK_IDX = 0,
    parameter int NUM_SRC  = 55,
    parameter int HOLE_LO  = 27,
    parameter int HOLE_HI  = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_t    wr_kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] irq_edge,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] wen_q,
    output logic [W-1:0] wpol_q,
    output logic         clr_hit
);
    logic [W-1:0] impl;
    logic [W-1:0] clr_vec;

    // Mark which bit positions carry a real source.
    for (genvar i = 0; i < W; i++) begin : g_impl
        localparam int GIDX = BANK_IDX * W + i;
        assign impl[i] = (GIDX < NUM_SRC) && !((GIDX >= HOLE_LO) && (GIDX <= HOLE_HI));
    end

    assign clr_vec = (wr_en && (wr_kind == KIND_STAT)) ? wdata : '0;
    assign clr_hit = |(clr_vec & impl);

    // Configuration registers, written whole by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            wen_q  <= '0;
            wpol_q <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                KIND_EN:   en_q   <= wdata;
                KIND_POL:  pol_q  <= wdata;
                KIND_WEN:  wen_q  <= wdata;
                KIND_WPOL: wpol_q <= wdata;
                default:   ;
            endcase
        end
    end

    // Pending bits: edge sets, write-one clears, edge wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~clr_vec) | irq_edge) & impl;
    end

    // R3: a pending bit only rises after a detected edge.
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(irq_edge)) == '0))
        else $error("pending bit set without an edge");

    // R6: cleared bits without a competing edge read zero afterwards.
    p_clear_applies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((pend_q & $past(clr_vec & ~irq_edge)) == '0))
        else $error("write-one-to-clear had no effect");

    // R10: an edge on an implemented bit always leaves it pending.
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_edge & impl)) |=> ((pend_q & $past(irq_edge & impl)) == $past(irq_edge & impl)))
        else $error("edge lost against clear");
endmodule

// File: rtl/edge_intc_combine.sv
// Merges all banks into the combined interrupt and the wake pulse.
// The interrupt is registered and held low for one cycle after any
// effective status clear so that a downstream edge detector re-fires.
module edge_intc_combine #(
    parameter int NB = 2,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB*W-1:0] active,
    input  logic [NB*W-1:0] wake_hit,
    input  logic [NB-1:0]   clr_hit,
    output logic          irq_out,
    output logic          wake_req
);
    logic irq_q, wake_q;

    // Register both outputs; a clear forces one low cycle on the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= (|active) && !(|clr_hit);
            wake_q <= |wake_hit;
        end
    end

    assign irq_out  = irq_q;
    assign wake_req = wake_q;

    // R8: the cycle after a clear write the combined output is low.
    p_clear_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_hit) |=> !irq_out)
        else $error("combined interrupt did not drop after clear");

    // R11: no wake pulse without an enabled wake edge the cycle before.
    p_wake_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(|wake_hit))
        else $error("wake pulse without cause");
endmodule

// File: rtl/edge_intc.sv
// Top of the two-bank edge interrupt controller. Pads the source vector to
// whole banks, builds one synchronizer and register bank per bank, decodes
// the word-addressed register bus and drives the combined outputs.
// Assumes single-cycle writes and combinational, side-effect-free reads.
module edge_intc
    import edge_intc_pkg::*;
#(
    parameter int NUM_SRC = 55,
    parameter int BANK_W  = 32,
    parameter int HOLE_LO = 27,
    parameter int HOLE_HI = 31,
    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W,
    localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_BITS + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BANK_W-1:0]  bus_wdata,
    output logic [BANK_W-1:0]  bus_rdata,
    output logic               irq_out,
    output logic               wake_req
);
    localparam int PAD_W = NUM_BANKS * BANK_W;

    logic [PAD_W-1:0]     src_pad;
    logic [PAD_W-1:0]     en_all, pol_all, pend_all, wen_all, wpol_all;
    logic [PAD_W-1:0]     edge_all, wedge_all, active, wake_hit;
    logic [NUM_BANKS-1:0] clr_hit;
    logic [BANK_BITS-1:0] addr_bank;
    reg_kind_t            addr_kind;

    assign src_pad   = PAD_W'(src_in);
    assign addr_bank = bus_addr[BANK_BITS-1:0];
    assign addr_kind = bus_addr[ADDR_W-1:BANK_BITS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr && (addr_bank == BANK_BITS'(b));

        edge_intc_sync #(.W(BANK_W)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (src_pad[b*BANK_W +: BANK_W]),
            .pol      (pol_all[b*BANK_W +: BANK_W]),
            .wpol     (wpol_all[b*BANK_W +: BANK_W]),
            .irq_edge (edge_all[b*BANK_W +: BANK_W]),
            .wake_edge(wedge_all[b*BANK_W +: BANK_W])
        );

        edge_intc_bank #(
            .W(BANK_W), .BANK_IDX(b), .NUM_SRC(NUM_SRC),
            .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .wr_kind (addr_kind),
            .wdata   (bus_wdata),
            .irq_edge(edge_all[b*BANK_W +: BANK_W]),
            .en_q    (en_all[b*BANK_W +: BANK_W]),
            .pol_q   (pol_all[b*BANK_W +: BANK_W]),
            .pend_q  (pend_all[b*BANK_W +: BANK_W]),
            .wen_q   (wen_all[b*BANK_W +: BANK_W]),
            .wpol_q  (wpol_all[b*BANK_W +: BANK_W]),
            .clr_hit (clr_hit[b])
        );
    end

    assign active   = pend_all & en_all;
    assign wake_hit = wedge_all & wen_all;

    // Read mux: pick the addressed bank, then the addressed register.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_bank == BANK_BITS'(b)) begin
                case (addr_kind)
                    KIND_STAT: bus_rdata = pend_all[b*BANK_W +: BANK_W];
                    KIND_EN:   bus_rdata = en_all[b*BANK_W +: BANK_W];
                    KIND_POL:  bus_rdata = pol_all[b*BANK_W +: BANK_W];
                    KIND_WEN:  bus_rdata = wen_all[b*BANK_W +: BANK_W];
                    KIND_WPOL: bus_rdata = wpol_all[b*BANK_W +: BANK_W];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    edge_intc_combine #(.NB(NUM_BANKS), .W(BANK_W)) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .wake_hit(wake_hit),
        .clr_hit (clr_hit),
        .irq_out (irq_out),
        .wake_req(wake_req)
    );

    // R7: the combined output never rises without an enabled pending bit.
    p_irq_needs_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(pend_all & en_all)))
        else $error("combined interrupt without enabled pending source");
endmodule

// File: tb/edge_intc_tb.sv
// Bench for the edge interrupt controller: a vector table of single-source
// edges, then directed tests for reset, latency, clears, retrigger, the
// edge/clear collision and wake pulses.
module edge_intc_tb;
    localparam int NSRC = 55;
    localparam int K_STAT = 0, K_EN = 1, K_POL = 2, K_WEN = 3, K_WPOL = 4;

    // Vector fields: {source index[7:0], polarity, enable}
    localparam logic [9:0] VEC [8] = '{
        {8'd0,  1'b0, 1'b1},
        {8'd5,  1'b1, 1'b1},
        {8'd26, 1'b0, 1'b1},
        {8'd27, 1'b0, 1'b1},
        {8'd31, 1'b1, 1'b1},
        {8'd32, 1'b0, 1'b1},
        {8'd40, 1'b1, 1'b0},
        {8'd54, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src;
    logic [3:0]      bus_addr;
    logic            bus_wr;
    logic [31:0]     bus_wdata, bus_rdata;
    logic            irq_out, wake_req;
    int              n_vec = 0;
    int              n_err = 0;
    bit              done  = 1'b0;

    always #2 clk = ~clk;

    edge_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int kind, input int bank, input logic [31:0] d);
        bus_addr  = 4'((kind << 1) | bank);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int kind, input int bank, output logic [31:0] d);
        bus_addr = 4'((kind << 1) | bank);
        #1;
        d = bus_rdata;
    endtask

    function automatic bit implemented(input int n);
        return (n < NSRC) && !((n >= 27) && (n <= 31));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int          idx, bk, wcount;
        bit          p, e;
        logic [31:0] m;

        rst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        for (int k = 0; k < 5; k++) begin
            for (int b = 0; b < 2; b++) begin
                rd(k, b, d);
                check("R1 register zero after reset", d, 32'h0);
            end
        end
        check("R1 irq_out low after reset", 32'(irq_out), 32'h0);
        check("R1 wake_req low after reset", 32'(wake_req), 32'h0);

        // R2: address map and read-back
        wr(K_EN, 0, 32'hA5A5_0F0F);
        rd(K_EN, 0, d); check("R2 enable bank0 read-back", d, 32'hA5A5_0F0F);
        rd(K_EN, 1, d); check("R2 enable bank1 untouched", d, 32'h0);
        wr(K_WPOL, 1, 32'h1234_5678);
        rd(K_WPOL, 1, d); check("R2 wake polarity bank1 read-back", d, 32'h1234_5678);
        wr(5, 0, 32'hFFFF_FFFF);
        rd(5, 0, d); check("R2 code 5 reads zero", d, 32'h0);
        rd(K_EN, 0, d); check("R2 code 5 write ignored", d, 32'hA5A5_0F0F);
        wr(K_EN, 0, 0); wr(K_WPOL, 1, 0);
        wr(K_STAT, 0, '1); wr(K_STAT, 1, '1);
        step(2);

        // Vector table: R3, R4, R5, R7
        for (int v = 0; v < 8; v++) begin
            idx = int'(VEC[v][9:2]);
            p   = VEC[v][1];
            e   = VEC[v][0];
            bk  = idx / 32;
            m   = 32'(1) << (idx % 32);
            wr(K_EN, bk, e ? m : 32'h0);
            if (p) begin
                src[idx] = 1'b1;
                step(4);
                wr(K_POL, bk, m);
            end
            wr(K_STAT, 0, '1); wr(K_STAT, 1, '1);
            step(2);
            src[idx] = !p;
            step(4);
            rd(K_STAT, bk, d);
            check(p ? "R4 falling edge status" : "R3 rising edge status",
                  d, implemented(idx) ? m : 32'h0);
            check(implemented(idx) ? "R7 irq follows enabled pending" : "R5 hole never raises irq",
                  32'(irq_out), 32'(implemented(idx) && e));
            src[idx] = 1'b0;
            step(4);
            wr(K_POL, bk, 0);
            wr(K_STAT, 0, '1); wr(K_STAT, 1, '1);
            wr(K_EN, bk, 0);
            step(2);
        end

        // R12 latency, R6 write-one-to-clear
        wr(K_EN, 0, 32'h4);
        src[2] = 1'b1;
        step(2);
        rd(K_STAT, 0, d); check("R12 not pending after two edges", d, 32'h0);
        step(1);
        rd(K_STAT, 0, d); check("R12 pending on third edge", d, 32'h4);
        check("R12 irq still low on third edge", 32'(irq_out), 32'h0);
        step(1);
        check("R12 irq high on fourth edge", 32'(irq_out), 32'h1);
        wr(K_STAT, 0, 32'h0);
        rd(K_STAT, 0, d); check("R6 zero write keeps pending", d, 32'h4);
        wr(K_STAT, 0, 32'h4);
        rd(K_STAT, 0, d); check("R6 one write clears", d, 32'h0);
        src[2] = 1'b0;
        step(4);
        check("R6 irq low after clear", 32'(irq_out), 32'h0);
        wr(K_EN, 0, 0);

        // R7 enabling an already pending source
        src[6] = 1'b1;
        step(4);
        rd(K_STAT, 0, d); check("R7 masked source still pending", d, 32'h40);
        check("R7 masked source keeps irq low", 32'(irq_out), 32'h0);
        wr(K_EN, 0, 32'h40);
        check("R7 irq not yet high in write cycle", 32'(irq_out), 32'h0);
        step(1);
        check("R7 irq high one cycle after enable", 32'(irq_out), 32'h1);
        wr(K_STAT, 0, '1); wr(K_EN, 0, 0);
        src[6] = 1'b0;
        step(4);

        // R8 partial clear pulses the output
        wr(K_EN, 0, 32'h3);
        src[1:0] = 2'b11;
        step(4);
        check("R8 irq high with two pending", 32'(irq_out), 32'h1);
        wr(K_STAT, 0, 32'h1);
        check("R8 irq drops after partial clear", 32'(irq_out), 32'h0);
        step(1);
        check("R8 irq reasserts for remaining source", 32'(irq_out), 32'h1);
        rd(K_STAT, 0, d); check("R8 remaining source pending", d, 32'h2);
        wr(K_STAT, 0, 32'h2);
        step(1);
        check("R8 irq stays low when nothing left", 32'(irq_out), 32'h0);
        src[1:0] = 2'b00;
        wr(K_EN, 0, 0);
        step(4);

        // R9 polarity flip retrigger, R4 falling mode ignores rise
        wr(K_EN, 0, 32'h8);
        wr(K_POL, 0, 32'h8);
        rd(K_STAT, 0, d); check("R9 not pending in write cycle", d, 32'h0);
        step(1);
        rd(K_STAT, 0, d); check("R9 low input, switch to falling retriggers", d, 32'h8);
        wr(K_STAT, 0, 32'h8);
        src[3] = 1'b1;
        step(4);
        rd(K_STAT, 0, d); check("R4 falling mode ignores rising input", d, 32'h0);
        wr(K_POL, 0, 0);
        step(1);
        rd(K_STAT, 0, d); check("R9 high input, switch to rising retriggers", d, 32'h8);
        wr(K_STAT, 0, 32'h8);
        src[3] = 1'b0;
        step(4);
        rd(K_STAT, 0, d); check("R3 rising mode ignores falling input", d, 32'h0);
        wr(K_EN, 0, 0);

        // R10 edge and clear in the same cycle
        src[4] = 1'b1;
        step(4);
        rd(K_STAT, 0, d); check("R10 setup pending", d, 32'h10);
        src[4] = 1'b0;
        step(4);
        src[4] = 1'b1;
        step(2);
        wr(K_STAT, 0, 32'h10);
        rd(K_STAT, 0, d); check("R10 edge wins over clear", d, 32'h10);
        wr(K_STAT, 0, 32'h10);
        rd(K_STAT, 0, d); check("R10 later clear works", d, 32'h0);
        src[4] = 1'b0;
        step(4);

        // R11 wake pulses
        wr(K_WEN, 1, 32'h100);
        src[40] = 1'b1;
        step(3);
        check("R11 wake pulse on rising edge", 32'(wake_req), 32'h1);
        step(1);
        check("R11 wake pulse lasts one cycle", 32'(wake_req), 32'h0);
        check("R11 wake independent of irq enable", 32'(irq_out), 32'h0);
        wr(K_WPOL, 1, 32'h100);
        step(2);
        src[40] = 1'b0;
        step(3);
        check("R11 wake pulse on falling edge", 32'(wake_req), 32'h1);
        step(1);
        check("R11 falling wake pulse ends", 32'(wake_req), 32'h0);
        wr(K_WPOL, 1, 0);
        wr(K_WEN, 1, 0);
        src[40] = 1'b1;
        wcount = 0;
        for (int c = 0; c < 6; c++) begin
            step(1);
            if (wake_req) wcount++;
        end
        check("R11 disabled wake gives no pulse", 32'(wcount), 32'h0);
        src[40] = 1'b0;
        step(4);
        wr(K_STAT, 0, '1); wr(K_STAT, 1, '1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule